// File: doc/BRIEF.md
# Configuration Header with Base Address Windows

This block holds the configuration header of one bus function: an identity word, a class word, a command register and a set of address windows. There are six base registers and one expansion ROM register. Each window has a fixed power-of-two size and a fixed kind (I/O or memory), both given by parameters. A host reaches the header through a single access port. Each access gives an 8-bit offset, a length code of byte, word or dword, and write data. Writes to the base registers keep only the address bits at or above the window size. Reads are put together little-endian from consecutive header bytes.

Every window is checked continuously against a set of rules. The matching command enable bit must be set. The ROM needs its own enable bit. The base must not be zero, the range must not wrap, and an I/O range must end below a ceiling. The result is presented as one enable flag per window with that window's first and last address. A small sequencer governs when these outputs change. It has two states. `ST_IDLE` holds the outputs. `ST_REFRESH` reloads them from the current register contents. Any write that touches the command register or stores a base register takes the transition IDLE→REFRESH. A further such write keeps the sequencer in REFRESH (REFRESH→REFRESH). A cycle with no such write returns it to IDLE (REFRESH→IDLE). The decode outputs therefore move one clock edge after the write that caused the change.

The top module exposes the window outputs to an address comparator that sits next to it. Window index 6 is the ROM. Indices 0 to 5 are the base registers.

Top module: `cfg_header_regs`

## Requirements
- R1: After reset the command register reads zero, all window enables, bases and limits are zero, `cfg_rdata` is zero, and each base register reads back only its hardwired type bit (bit 0 = 1 for a sized I/O window, 0 otherwise).
- R2: A dword write with `cfg_len`=2 at offset 0x10+4*n stores the data with all bits below the window size cleared. Readback ORs in the hardwired type bit 0 (1 for I/O). A window of size zero stores nothing and reads 0.
- R3: A dword write at offset 0x30 (ROM) clears the bits below the ROM size except bit 0, which is kept as the ROM enable.
- R4: Byte or word writes, and dword writes at an offset that is not exactly a register's start, leave every base and ROM register unchanged.
- R5: The command register at offsets 0x04/0x05 takes byte-lane writes from any access whose bytes cover those offsets. Only bits 0 (I/O enable), 1 (memory enable) and 2 (master enable) are writable. All other bits read 0.
- R6: A read with `cfg_len` 0, 1 or 2 returns 1, 2 or 4 bytes from offset, offset+1, … (wrapping 0xFF→0x00) packed little-endian, with unused upper bytes zero. `cfg_rdata` is registered on the edge that samples `cfg_rd`. Length code 3 reads 0 and writes nothing.
- R7: Offsets 0x00–0x03 return the `ID_WORD` parameter and 0x08–0x0B the `CLASS_WORD` parameter. Both ignore writes. Other unlisted offsets read 0.
- R8: An I/O window is enabled only while command bit 0 is set, its base is nonzero, base+size−1 exceeds the base, and base+size−1 is below `IO_LIMIT` (0x10000 by default).
- R9: A memory window is enabled only while command bit 1 is set, its base is nonzero, and base+size−1 exceeds the base.
- R10: The ROM window additionally requires bit 0 of the ROM register to be set. Its base is the register with bit 0 cleared.
- R11: Window outputs change on the clock edge after the triggering write, not on the write's own edge. A disabled window shows base and limit 0. An enabled window shows its base and base+size−1.
- R12: A window whose size parameter is zero is never enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for this cycle |
| cfg_rd | input | 1 | Read strobe for this cycle |
| cfg_off | input | 8 | Header byte offset |
| cfg_len | input | 2 | 0 byte, 1 word, 2 dword, 3 none |
| cfg_wdata | input | 32 | Write data, byte 0 in bits 7:0 |
| cfg_rdata | output | 32 | Registered read data |
| win_en | output | NUM_BARS+1 | Per-window decode enable |
| win_base | output | 32*(NUM_BARS+1) | Per-window first address |
| win_limit | output | 32*(NUM_BARS+1) | Per-window last address |

## Verification
The hardest cases to reach are the window checks that sit at their limits. Examples are an I/O window whose last address is exactly 0xFFFF next to one starting at 0x10000, a memory window ending at 0xFFFFFFFF, and a ROM whose address is valid but whose enable bit is clear. All of these must be seen under every combination of the two command enables. The bench sweeps every window through a fixed set of base patterns chosen to land on these edges, under all four command settings. It computes the expected stored value and decode result arithmetically from the size and kind. It also snapshots the outputs just before each base write and confirms they hold for exactly one edge.

// File: rtl/cfgh_pkg.sv
package cfgh_pkg;

    typedef enum logic [1:0] {
        LEN_BYTE  = 2'd0,
        LEN_WORD  = 2'd1,
        LEN_DWORD = 2'd2,
        LEN_NONE  = 2'd3
    } acc_len_e;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_REFRESH = 1'b1
    } refresh_state_e;

    localparam logic [7:0]  OFF_ID     = 8'h00;
    localparam logic [7:0]  OFF_CMD    = 8'h04;
    localparam logic [7:0]  OFF_CLASS  = 8'h08;
    localparam logic [7:0]  OFF_BAR0   = 8'h10;
    localparam logic [7:0]  OFF_ROM    = 8'h30;
    localparam logic [15:0] CMD_WMASK  = 16'h0007;

    function automatic logic [31:0] size_mask(input logic [31:0] sz);
        return ~(sz - 32'd1);
    endfunction

    function automatic int len_bytes(input acc_len_e l);
        case (l)
            LEN_BYTE:  return 1;
            LEN_WORD:  return 2;
            LEN_DWORD: return 4;
            default:   return 0;
        endcase
    endfunction

endpackage

// File: rtl/cfgh_bar_slot.sv
module cfgh_bar_slot
    import cfgh_pkg::*;
#(
    parameter logic [31:0] SIZE   = 32'h10,
    parameter bit          IS_IO  = 1'b0,
    parameter bit          IS_ROM = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_stb,
    input  logic [31:0] wdata,
    output logic [31:0] rd_word,
    output logic [31:0] base_o,
    output logic        rom_on_o
);
    localparam logic [31:0] ADDR_MASK = size_mask(SIZE);
    localparam logic [31:0] KEEP      = IS_ROM ? (ADDR_MASK | 32'h1) : ADDR_MASK;
    localparam logic [31:0] TYPE_BITS = (IS_IO && (SIZE != 32'd0)) ? 32'h1 : 32'h0;

    logic [31:0] stored_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stored_q <= '0;
        end else if (wr_stb) begin
            stored_q <= wdata & KEEP;
        end
    end

    assign rd_word  = stored_q | TYPE_BITS;
    assign base_o   = stored_q & ADDR_MASK;
    assign rom_on_o = IS_ROM ? stored_q[0] : 1'b1;

endmodule

// File: rtl/cfgh_region_check.sv
module cfgh_region_check #(
    parameter logic [31:0] SIZE     = 32'h10,
    parameter bit          IS_IO    = 1'b0,
    parameter logic [31:0] IO_LIMIT = 32'h0001_0000
) (
    input  logic [31:0] base,
    input  logic        rom_on,
    input  logic        io_on,
    input  logic        mem_on,
    output logic        hit,
    output logic [31:0] lo,
    output logic [31:0] hi
);
    logic [31:0] last;
    logic        space_on;
    logic        ok;

    always_comb begin
        last     = base + SIZE - 32'd1;
        space_on = IS_IO ? io_on : mem_on;
        ok       = (SIZE != 32'd0) && space_on && rom_on
                   && (base != 32'd0) && (last > base)
                   && (!IS_IO || (last < IO_LIMIT));
        hit      = ok;
        lo       = ok ? base : 32'd0;
        hi       = ok ? last : 32'd0;
    end

endmodule

// File: rtl/cfgh_refresh_fsm.sv
module cfgh_refresh_fsm
    import cfgh_pkg::*;
#(
    parameter int NREG = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trigger,
    input  logic [NREG-1:0]      nxt_en,
    input  logic [NREG*32-1:0]   nxt_lo,
    input  logic [NREG*32-1:0]   nxt_hi,
    output logic [NREG-1:0]      en_q,
    output logic [NREG*32-1:0]   lo_q,
    output logic [NREG*32-1:0]   hi_q
);
    refresh_state_e state_q, state_d;

    always_comb begin
        unique case (state_q)
            ST_IDLE:    state_d = trigger ? ST_REFRESH : ST_IDLE;
            ST_REFRESH: state_d = trigger ? ST_REFRESH : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
            lo_q <= '0;
            hi_q <= '0;
        end else if (state_q == ST_REFRESH) begin
            en_q <= nxt_en;
            lo_q <= nxt_lo;
            hi_q <= nxt_hi;
        end
    end

    // Outputs may only move on an edge taken in the refresh state.
    assert_hold_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> ($stable(en_q) && $stable(lo_q) && $stable(hi_q)));

    assert_trigger_enters_refresh_R11: assert property (@(posedge clk) disable iff (!rst_n)
        trigger |=> (state_q == ST_REFRESH));

endmodule

// File: rtl/cfg_header_regs.sv
module cfg_header_regs
    import cfgh_pkg::*;
#(
    parameter int                      NUM_BARS   = 6,
    parameter logic [NUM_BARS*32-1:0]  BAR_SIZE   = {32'h10, 32'h4, 32'h0, 32'h100, 32'h1000, 32'h10},
    parameter logic [NUM_BARS-1:0]     BAR_IO     = 6'b010101,
    parameter logic [31:0]             ROM_SIZE   = 32'h800,
    parameter logic [31:0]             ID_WORD    = 32'h5A3C_1B2D,
    parameter logic [31:0]             CLASS_WORD = 32'h0880_0002,
    parameter logic [31:0]             IO_LIMIT   = 32'h0001_0000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_wr,
    input  logic                          cfg_rd,
    input  logic [7:0]                    cfg_off,
    input  logic [1:0]                    cfg_len,
    input  logic [31:0]                   cfg_wdata,
    output logic [31:0]                   cfg_rdata,
    output logic [NUM_BARS:0]             win_en,
    output logic [(NUM_BARS+1)*32-1:0]    win_base,
    output logic [(NUM_BARS+1)*32-1:0]    win_limit
);
    localparam int         NREG    = NUM_BARS + 1;
    localparam int         ROM_IDX = NUM_BARS;
    localparam logic [7:0] BAR_END = OFF_BAR0 + 8'(4 * NUM_BARS);

    acc_len_e    len_e;
    int          nbytes;
    logic [15:0] cmd_q, cmd_d;
    logic        cmd_touch;
    logic [NREG-1:0] slot_stb;
    logic        trigger;

    logic [31:0] word_arr [NREG];
    logic [31:0] base_arr [NREG];
    logic        rom_on_arr [NREG];
    logic [NREG-1:0]    nxt_en;
    logic [NREG*32-1:0] nxt_lo, nxt_hi;
    logic [NREG*32-1:0] slot_flat;
    logic [31:0] rd_asm;

    assign len_e  = acc_len_e'(cfg_len);
    assign nbytes = len_bytes(len_e);

    // Byte-lane write path for the command register.
    always_comb begin
        logic [7:0] lane;
        cmd_d     = cmd_q;
        cmd_touch = 1'b0;
        for (int i = 0; i < 4; i++) begin
            lane = cfg_off + 8'(i);
            if (cfg_wr && (i < nbytes)) begin
                if (lane == OFF_CMD) begin
                    cmd_d[7:0] = cfg_wdata[8*i +: 8] & CMD_WMASK[7:0];
                    cmd_touch  = 1'b1;
                end else if (lane == OFF_CMD + 8'd1) begin
                    cmd_d[15:8] = cfg_wdata[8*i +: 8] & CMD_WMASK[15:8];
                    cmd_touch   = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= cmd_d;
    end

    // Base register slots and their window checks.
    for (genvar j = 0; j < NREG; j++) begin : g_slot
        localparam bit          ROM_SLOT = (j == ROM_IDX);
        localparam logic [31:0] SZ       = ROM_SLOT ? ROM_SIZE : BAR_SIZE[(ROM_SLOT ? 0 : j)*32 +: 32];
        localparam bit          IO_SLOT  = ROM_SLOT ? 1'b0 : BAR_IO[ROM_SLOT ? 0 : j];
        localparam logic [7:0]  SLOT_OFF = ROM_SLOT ? OFF_ROM : (OFF_BAR0 + 8'(4 * j));

        assign slot_stb[j] = cfg_wr && (len_e == LEN_DWORD) && (cfg_off == SLOT_OFF);

        cfgh_bar_slot #(.SIZE(SZ), .IS_IO(IO_SLOT), .IS_ROM(ROM_SLOT)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_stb   (slot_stb[j]),
            .wdata    (cfg_wdata),
            .rd_word  (word_arr[j]),
            .base_o   (base_arr[j]),
            .rom_on_o (rom_on_arr[j])
        );

        cfgh_region_check #(.SIZE(SZ), .IS_IO(IO_SLOT), .IO_LIMIT(IO_LIMIT)) u_check (
            .base   (base_arr[j]),
            .rom_on (rom_on_arr[j]),
            .io_on  (cmd_q[0]),
            .mem_on (cmd_q[1]),
            .hit    (nxt_en[j]),
            .lo     (nxt_lo[j*32 +: 32]),
            .hi     (nxt_hi[j*32 +: 32])
        );

        assign slot_flat[j*32 +: 32] = word_arr[j];

        assert_span_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
            win_en[j] |-> (win_limit[j*32 +: 32] > win_base[j*32 +: 32]));

        if (IO_SLOT) begin : g_io_chk
            assert_io_ceiling_R8: assert property (@(posedge clk) disable iff (!rst_n)
                win_en[j] |-> (win_limit[j*32 +: 32] < IO_LIMIT));
            assert_io_needs_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
                win_en[j] |-> $past(cmd_q[0]));
        end else begin : g_mem_chk
            assert_mem_needs_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
                win_en[j] |-> $past(cmd_q[1]));
        end
    end

    assign trigger = (|slot_stb) | cmd_touch;

    cfgh_refresh_fsm #(.NREG(NREG)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .trigger (trigger),
        .nxt_en  (nxt_en),
        .nxt_lo  (nxt_lo),
        .nxt_hi  (nxt_hi),
        .en_q    (win_en),
        .lo_q    (win_base),
        .hi_q    (win_limit)
    );

    // Read path: one header byte per offset.
    function automatic logic [7:0] byte_at(input logic [7:0] a);
        logic [7:0] r;
        r = 8'h00;
        if (a < OFF_CMD)
            r = ID_WORD[8*int'(a[1:0]) +: 8];
        else if (a == OFF_CMD)
            r = cmd_q[7:0];
        else if (a == OFF_CMD + 8'd1)
            r = cmd_q[15:8];
        else if (a >= OFF_CLASS && a < OFF_CLASS + 8'd4)
            r = CLASS_WORD[8*int'(a[1:0]) +: 8];
        else if (a >= OFF_BAR0 && a < BAR_END)
            r = word_arr[int'((a - OFF_BAR0) >> 2)][8*int'(a[1:0]) +: 8];
        else if (a >= OFF_ROM && a < OFF_ROM + 8'd4)
            r = word_arr[ROM_IDX][8*int'(a[1:0]) +: 8];
        return r;
    endfunction

    always_comb begin
        rd_asm = '0;
        for (int i = 0; i < 4; i++) begin
            if (i < nbytes) rd_asm[8*i +: 8] = byte_at(cfg_off + 8'(i));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_rdata <= '0;
        else if (cfg_rd) cfg_rdata <= rd_asm;
    end

    assert_short_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && (slot_stb == '0)) |=> $stable(slot_flat));

    assert_rom_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        win_en[ROM_IDX] |-> $past(word_arr[ROM_IDX][0]));

endmodule

// File: tb/cfg_header_regs_test.sv
module cfg_header_regs_test;
    localparam logic [31:0] IDW = 32'h5A3C_1B2D;
    localparam logic [31:0] CLW = 32'h0880_0002;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
    logic [7:0]  cfg_off = '0;
    logic [1:0]  cfg_len = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [6:0]  win_en;
    logic [223:0] win_base, win_limit;

    int total = 0, bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    cfg_header_regs #(
        .NUM_BARS(6),
        .BAR_SIZE({32'h10, 32'h4, 32'h0, 32'h100, 32'h1000, 32'h10}),
        .BAR_IO(6'b010101),
        .ROM_SIZE(32'h800),
        .ID_WORD(IDW),
        .CLASS_WORD(CLW),
        .IO_LIMIT(32'h0001_0000)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_off(cfg_off), .cfg_len(cfg_len), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .win_en(win_en), .win_base(win_base), .win_limit(win_limit)
    );

    function automatic logic [31:0] sz(input int r);
        case (r)
            0: return 32'h10;   1: return 32'h1000; 2: return 32'h100;
            3: return 32'h0;    4: return 32'h4;    5: return 32'h10;
            default: return 32'h800;
        endcase
    endfunction
    function automatic bit is_io(input int r);
        return (r == 0) || (r == 2) || (r == 4);
    endfunction
    function automatic logic [7:0] off_of(input int r);
        return (r == 6) ? 8'h30 : 8'(8'h10 + 4 * r);
    endfunction
    function automatic logic [31:0] pat(input int k);
        case (k)
            0: return 32'h0000_0000; 1: return 32'hFFFF_FFFF;
            2: return 32'h0000_FF00; 3: return 32'h0001_0000;
            4: return 32'h0000_FFF3; 5: return 32'hFFFF_F001;
            6: return 32'h1234_5679; default: return 32'h0000_0801;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] o, input logic [1:0] l, input logic [31:0] d);
        cfg_wr = 1'b1; cfg_off = o; cfg_len = l; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] o, input logic [1:0] l, output logic [31:0] d);
        cfg_rd = 1'b1; cfg_off = o; cfg_len = l;
        @(negedge clk);
        cfg_rd = 1'b0;
        d = cfg_rdata;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        logic [6:0]  snap_en;
        logic [223:0] snap_b, snap_l;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 win_en", {25'd0, win_en}, 32'd0);
        check("R1 win_base", {31'd0, |win_base}, 32'd0);
        check("R1 rdata", cfg_rdata, 32'd0);
        rd(8'h04, 2'd1, v); check("R1 cmd", v, 32'd0);
        rd(8'h10, 2'd2, v); check("R1 io type bit", v, 32'd1);
        rd(8'h14, 2'd2, v); check("R1 mem bar", v, 32'd0);
        rd(8'h1C, 2'd2, v); check("R1 absent bar", v, 32'd0);

        // R7 identity and class, read-only
        wr(8'h00, 2'd2, 32'hFFFF_FFFF);
        wr(8'h08, 2'd2, 32'h0000_0000);
        rd(8'h00, 2'd2, v); check("R7 id", v, IDW);
        rd(8'h08, 2'd2, v); check("R7 class", v, CLW);
        rd(8'h40, 2'd2, v); check("R7 unlisted", v, 32'd0);

        // R6 lengths, packing, wrap, none-code
        rd(8'h00, 2'd0, v); check("R6 byte", v, {24'd0, IDW[7:0]});
        rd(8'h01, 2'd1, v); check("R6 word", v, {16'd0, IDW[23:8]});
        rd(8'hFE, 2'd2, v); check("R6 wrap", v, {IDW[15:0], 16'd0});
        rd(8'h00, 2'd3, v); check("R6 none read", v, 32'd0);

        // R5 command register lanes and mask
        wr(8'h04, 2'd0, 32'h0000_00FF);
        rd(8'h04, 2'd1, v); check("R5 byte lo", v, 32'h7);
        wr(8'h05, 2'd0, 32'h0000_00FF);
        rd(8'h04, 2'd1, v); check("R5 byte hi", v, 32'h7);
        wr(8'h04, 2'd1, 32'h0000_0000);
        rd(8'h04, 2'd1, v); check("R5 word clear", v, 32'h0);
        wr(8'h02, 2'd2, 32'h0005_0000);
        rd(8'h04, 2'd1, v); check("R5 unaligned dword lane", v, 32'h5);
        wr(8'h04, 2'd3, 32'h0000_00FF);
        rd(8'h04, 2'd1, v); check("R6 none write", v, 32'h5);
        rd(8'h02, 2'd2, v); check("R6 dword span", v, {16'h0005, IDW[31:16]});
        wr(8'h04, 2'd1, 32'h0);

        // R4 short and misaligned writes ignored
        wr(8'h14, 2'd2, 32'h0000_2000);
        wr(8'h14, 2'd0, 32'hFFFF_FFFF);
        wr(8'h16, 2'd1, 32'hFFFF_FFFF);
        wr(8'h15, 2'd2, 32'hFFFF_FFFF);
        rd(8'h14, 2'd2, v); check("R4 bar short write", v, 32'h0000_2000);
        wr(8'h30, 2'd0, 32'hFF);
        rd(8'h30, 2'd2, v); check("R4 rom byte write", v, 32'h0);

        // Sweep: every window x base pattern x command setting
        for (int r = 0; r < 7; r++) begin
            for (int k = 0; k < 8; k++) begin
                for (int c = 0; c < 4; c++) begin
                    logic [31:0] s, m, st, base, last, rb;
                    bit en;
                    s  = sz(r);
                    m  = ~(s - 32'd1);
                    st = pat(k) & ((r == 6) ? (m | 32'h1) : m);
                    rb = st | ((is_io(r) && s != 0) ? 32'h1 : 32'h0);
                    base = st & m;
                    last = base + s - 32'd1;
                    en = (s != 0) && (is_io(r) ? c[0] : c[1]) && ((r == 6) ? st[0] : 1'b1)
                         && (base != 0) && (last > base) && (!is_io(r) || last < 32'h1_0000);

                    wr(8'h04, 2'd1, 32'(c));
                    @(negedge clk);
                    snap_en = win_en; snap_b = win_base; snap_l = win_limit;
                    wr(off_of(r), 2'd2, pat(k));
                    // R11: not yet on the write's own edge
                    check("R11 hold en", {25'd0, win_en}, {25'd0, snap_en});
                    check("R11 hold base", win_base[r*32 +: 32], snap_b[r*32 +: 32]);
                    check("R11 hold limit", win_limit[r*32 +: 32], snap_l[r*32 +: 32]);
                    @(negedge clk);
                    if (r == 3)
                        check("R12 absent window", {31'd0, win_en[r]}, 32'd0);
                    else if (r == 6)
                        check("R10 rom enable", {31'd0, win_en[r]}, {31'd0, en});
                    else if (is_io(r))
                        check("R8 io decode", {31'd0, win_en[r]}, {31'd0, en});
                    else
                        check("R9 mem decode", {31'd0, win_en[r]}, {31'd0, en});
                    check("R11 base", win_base[r*32 +: 32], en ? base : 32'd0);
                    check("R11 limit", win_limit[r*32 +: 32], en ? last : 32'd0);
                    rd(off_of(r), 2'd2, v);
                    if (r == 6) check("R3 rom store", v, rb);
                    else        check("R2 bar store", v, rb);
                end
            end
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule